// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is a purely combinational integer ALU with a default width of 32 bits. It takes two operands and a 3-bit function code. It returns a result word together with zero, signed-overflow and carry-out flags. The supported functions are bitwise AND, bitwise OR, addition, subtraction and a signed less-than test. An execute stage would place it between operand selection and the writeback or branch-decision logic. The zero flag serves as the equality test for branches.

The top bit of the function code is a negate line. It inverts the B operand and also feeds the carry into bit 0, so subtraction is A plus the complement of B plus one. The two low bits pick the output of each bit slice: AND, OR, sum, or the less input.

The less-than test subtracts B from A. It then corrects the sign of the difference with the overflow signal, so the answer is right even when the difference wraps. The corrected bit is routed back to bit 0 of the result. All other result bits are zero for this function.

Top module: `int_alu`

## Requirements
- R1: Code 000 gives result = A AND B, bit by bit.
- R2: Code 001 gives result = A OR B, bit by bit.
- R3: Code 010 gives result = (A + B) mod 2^WIDTH. The carry flag is the carry out of the top bit.
- R4: Code 110 gives result = (A + NOT B + 1) mod 2^WIDTH. The carry flag is the carry out of the top bit, which is 1 exactly when A >= B as unsigned numbers.
- R5: For codes 010, 110 and 111, the overflow flag is the carry into the top bit XOR the carry out of it. This equals 1 exactly when the signed result of A+B (010) or A-B (110, 111) falls outside the two's-complement range. Adding operands of different signs, or subtracting operands of equal sign, never sets it.
- R6: Code 111 gives result bit 0 = 1 when A < B as signed two's-complement numbers, and 0 otherwise. That bit is the top bit of A-B XOR the overflow. Result bits 1 and up are 0.
- R7: The zero flag is 1 exactly when every result bit is 0.
- R8: Codes 011, 100 and 101 give a result of 0, with overflow and carry both 0.
- R9: Codes 000 and 001 drive the overflow and carry flags to 0. Code 111 drives the carry flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand, inverted when the negate line is set |
| alu_ctl | input | 3 | Function code: bit 2 is negate, bits 1:0 select the slice output |
| result | output | WIDTH | Selected result word |
| zero_flag | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow for add, subtract and less-than |
| carry_flag | output | 1 | Carry out of the top bit for add and subtract |

## Verification
The assertions check several properties on every input change:
- Mixed-sign addition and same-sign subtraction never raise overflow.
- The subtract carry agrees with an unsigned comparison of the operands.
- The less-than bit agrees with a signed comparison, and its upper result bits stay clear.
- A zero flag during subtraction implies equal operands.
- Unused codes and the logic functions leave their flags low.

The exact sum and difference words need the bench's scenarios. So do the overflow value on the wrap cases and the less-than answer when the raw difference has the wrong sign. The bench sweeps every code and operand pair on a 4-bit instance and compares each one with a signed-integer model. It then checks the 32-bit instance at its range boundaries.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  // Slice output select, carried in the two low bits of the function code
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_SUM  = 2'b10,
    FN_LESS = 2'b11
  } alu_fn_e;

  localparam logic [2:0] CTL_AND = 3'b000;
  localparam logic [2:0] CTL_OR  = 3'b001;
  localparam logic [2:0] CTL_ADD = 3'b010;
  localparam logic [2:0] CTL_SUB = 3'b110;
  localparam logic [2:0] CTL_SLT = 3'b111;

  // Sum bit of a full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // Carry of a full adder: majority of the three inputs
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // Codes whose overflow flag is meaningful
  function automatic logic ctl_is_arith(input logic [2:0] c);
    return (c == CTL_ADD) || (c == CTL_SUB) || (c == CTL_SLT);
  endfunction

  // Codes that report a carry out
  function automatic logic ctl_has_carry(input logic [2:0] c);
    return (c == CTL_ADD) || (c == CTL_SUB);
  endfunction

  // Codes that produce a defined result
  function automatic logic ctl_is_defined(input logic [2:0] c);
    return (c == CTL_AND) || (c == CTL_OR) || ctl_is_arith(c);
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import int_alu_pkg::*;
(
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    negate,
  input  logic    carry_in,
  input  logic    less_in,
  input  alu_fn_e fn,
  output logic    sum_bit,
  output logic    res_bit,
  output logic    carry_out
);

  logic b_eff;

  assign b_eff     = b_bit ^ negate;
  assign sum_bit   = fa_sum(a_bit, b_eff, carry_in);
  assign carry_out = fa_carry(a_bit, b_eff, carry_in);

  always_comb begin
    unique case (fn)
      FN_AND:  res_bit = a_bit & b_eff;
      FN_OR:   res_bit = a_bit | b_eff;
      FN_SUM:  res_bit = sum_bit;
      FN_LESS: res_bit = less_in;
      default: res_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic             negate,
  input  alu_fn_e          fn,
  input  logic             less_lsb,
  output logic [WIDTH-1:0] sum_vec,
  output logic [WIDTH-1:0] res_vec,
  output logic [WIDTH:0]   carry_vec
);

  // The negate line doubles as the carry into bit 0
  assign carry_vec[0] = negate;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_i;
    if (i == 0) begin : g_lsb
      assign less_i = less_lsb;
    end else begin : g_upper
      assign less_i = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_bit    (a_vec[i]),
      .b_bit    (b_vec[i]),
      .negate   (negate),
      .carry_in (carry_vec[i]),
      .less_in  (less_i),
      .fn       (fn),
      .sum_bit  (sum_vec[i]),
      .res_bit  (res_vec[i]),
      .carry_out(carry_vec[i+1])
    );
  end

  // R4: a subtraction carries out exactly when A >= B unsigned
  always_comb begin
    if (negate && (fn == FN_SUM)) begin
      assert_sub_carry_R4: assert (carry_vec[WIDTH] == (a_vec >= b_vec))
        else $error("subtract carry disagrees with unsigned compare");
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit (
  input  logic a_msb,
  input  logic b_msb,
  input  logic negate,
  input  logic carry_into_msb,
  input  logic carry_out_msb,
  input  logic diff_msb,
  output logic ovf_raw,
  output logic set_bit
);

  // Overflow from the two carries around the top bit
  assign ovf_raw = carry_into_msb ^ carry_out_msb;
  // Corrected sign of A-B
  assign set_bit = diff_msb ^ ovf_raw;

  always_comb begin
    // R5: mixed-sign addition never overflows
    if (!negate && (a_msb != b_msb)) begin
      assert_add_mixed_no_ovf_R5: assert (!ovf_raw)
        else $error("overflow on mixed-sign addition");
    end
    // R5: subtracting operands of the same sign never overflows
    if (negate && (a_msb == b_msb)) begin
      assert_sub_same_no_ovf_R5: assert (!ovf_raw)
        else $error("overflow on same-sign subtraction");
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [2:0]       alu_ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag,
  output logic             carry_flag
);

  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn_sel;
  logic             negate;
  logic [WIDTH-1:0] sum_vec;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH:0]   carry_vec;
  logic             ovf_raw;
  logic             set_bit;
  logic             code_defined;
  logic             code_arith;
  logic             code_carry;

  assign negate       = alu_ctl[2];
  assign fn_sel       = alu_fn_e'(alu_ctl[1:0]);
  assign code_defined = ctl_is_defined(alu_ctl);
  assign code_arith   = ctl_is_arith(alu_ctl);
  assign code_carry   = ctl_has_carry(alu_ctl);

  alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec    (a_in),
    .b_vec    (b_in),
    .negate   (negate),
    .fn       (fn_sel),
    .less_lsb (set_bit),
    .sum_vec  (sum_vec),
    .res_vec  (slice_res),
    .carry_vec(carry_vec)
  );

  alu_flag_unit u_flags (
    .a_msb         (a_in[MSB]),
    .b_msb         (b_in[MSB]),
    .negate        (negate),
    .carry_into_msb(carry_vec[MSB]),
    .carry_out_msb (carry_vec[WIDTH]),
    .diff_msb      (sum_vec[MSB]),
    .ovf_raw       (ovf_raw),
    .set_bit       (set_bit)
  );

  assign result     = code_defined ? slice_res : '0;
  assign ovf_flag   = code_arith & ovf_raw;
  assign carry_flag = code_carry & carry_vec[WIDTH];
  assign zero_flag  = ~|result;

  always_comb begin
    if (alu_ctl == CTL_SLT) begin
      // R6: less-than bit follows the signed comparison
      assert_slt_signed_R6: assert (result[0] == ($signed(a_in) < $signed(b_in)))
        else $error("less-than bit wrong");
      // R6: upper bits of the less-than result stay clear
      assert_slt_upper_clear_R6: assert (result[MSB:1] == '0)
        else $error("less-than upper bits set");
      // R9: no carry reported for less-than
      assert_slt_no_carry_R9: assert (!carry_flag)
        else $error("carry flag set on less-than");
    end
    // R7: zero after subtraction means the operands were equal
    if ((alu_ctl == CTL_SUB) && zero_flag) begin
      assert_sub_zero_equal_R7: assert (a_in == b_in)
        else $error("zero flag on unequal subtraction");
    end
    // R8: unused codes stay quiet
    if (!code_defined) begin
      assert_unused_quiet_R8: assert ((result == '0) && !ovf_flag && !carry_flag && zero_flag)
        else $error("unused code produced output");
    end
    // R9: logic functions raise no arithmetic flags
    if ((alu_ctl == CTL_AND) || (alu_ctl == CTL_OR)) begin
      assert_logic_no_flags_R9: assert (!ovf_flag && !carry_flag)
        else $error("flag set on logic function");
    end
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  localparam int W_BIG   = 32;
  localparam int W_SMALL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W_BIG-1:0]   a_big, b_big, r_big;
  logic [2:0]         ctl_big;
  logic               z_big, o_big, c_big;
  logic [W_SMALL-1:0] a_sm, b_sm, r_sm;
  logic [2:0]         ctl_sm;
  logic               z_sm, o_sm, c_sm;

  int_alu #(.WIDTH(W_BIG)) u_dut (
    .a_in(a_big), .b_in(b_big), .alu_ctl(ctl_big),
    .result(r_big), .zero_flag(z_big), .ovf_flag(o_big), .carry_flag(c_big)
  );

  int_alu #(.WIDTH(W_SMALL)) u_small (
    .a_in(a_sm), .b_in(b_sm), .alu_ctl(ctl_sm),
    .result(r_sm), .zero_flag(z_sm), .ovf_flag(o_sm), .carry_flag(c_sm)
  );

  // Reference model on signed integers
  task automatic model(input int w, input longint a, input longint b, input int ctl,
                       output longint r, output bit z, output bit o, output bit c);
    longint m    = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint sa   = (a >= half) ? a - (longint'(1) << w) : a;
    longint sb   = (b >= half) ? b - (longint'(1) << w) : b;
    longint tru  = 0;
    r = 0; o = 0; c = 0;
    case (ctl)
      0: r = a & b;
      1: r = a | b;
      2: begin tru = sa + sb; r = (a + b) & m; c = ((a + b) >> w) != 0;
               o = (tru > half - 1) || (tru < -half); end
      6: begin tru = sa - sb; r = (a - b) & m; c = (a >= b);
               o = (tru > half - 1) || (tru < -half); end
      7: begin tru = sa - sb; r = (sa < sb) ? 1 : 0;
               o = (tru > half - 1) || (tru < -half); end
      default: r = 0;
    endcase
    z = (r == 0);
  endtask

  function automatic string tag_of(input int ctl);
    case (ctl)
      0: return "R1/R7/R9";
      1: return "R2/R7/R9";
      2: return "R3/R5/R7";
      6: return "R4/R5/R7";
      7: return "R6/R5/R9";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string tag, input longint a, input longint b, input int ctl,
                         input longint r, input bit z, input bit o, input bit c,
                         input longint er, input bit ez, input bit eo, input bit ec);
    checks++;
    if (r != er || z != ez || o != eo || c != ec) begin
      errors++;
      $display("FAIL %s ctl=%0d a=%0h b=%0h: got r=%0h z=%0b o=%0b c=%0b exp r=%0h z=%0b o=%0b c=%0b",
               tag, ctl, a, b, r, z, o, c, er, ez, eo, ec);
    end
  endtask

  task automatic run_small(input int a, input int b, input int ctl);
    longint er; bit ez, eo, ec;
    @(negedge clk);
    a_sm = W_SMALL'(a); b_sm = W_SMALL'(b); ctl_sm = 3'(ctl);
    @(posedge clk); #1;
    model(W_SMALL, longint'(a), longint'(b), ctl, er, ez, eo, ec);
    compare(tag_of(ctl), longint'(a), longint'(b), ctl,
            longint'(r_sm), z_sm, o_sm, c_sm, er, ez, eo, ec);
  endtask

  task automatic run_big(input logic [31:0] a, input logic [31:0] b, input int ctl);
    longint er; bit ez, eo, ec;
    @(negedge clk);
    a_big = a; b_big = b; ctl_big = 3'(ctl);
    @(posedge clk); #1;
    model(W_BIG, longint'(a), longint'(b), ctl, er, ez, eo, ec);
    compare(tag_of(ctl), longint'(a), longint'(b), ctl,
            longint'(r_big), z_big, o_big, c_big, er, ez, eo, ec);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a_big = '0; b_big = '0; ctl_big = 3'b000;
    a_sm = '0; b_sm = '0; ctl_sm = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-time state: AND of zeros gives zero result, zero flag set (R7, R1)
    @(posedge clk); #1;
    compare("R1/R7 idle", 0, 0, 0, longint'(r_big), z_big, o_big, c_big, 0, 1'b1, 1'b0, 1'b0);

    // Exhaustive sweep of the 4-bit instance: R1..R9
    for (int ctl = 0; ctl < 8; ctl++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_small(a, b, ctl);

    // 32-bit boundaries
    run_big(32'h7FFF_FFFF, 32'h0000_0001, 2);  // R5 positive wrap
    run_big(32'h8000_0000, 32'h8000_0000, 2);  // R3 carry, R5, R7 zero
    run_big(32'hFFFF_FFFF, 32'h0000_0001, 2);  // R3 carry, no overflow
    run_big(32'hFFFF_FFF9, 32'h0000_0006, 6);  // R4: -7 - 6
    run_big(32'h8000_0000, 32'h0000_0001, 6);  // R5 negative wrap
    run_big(32'h1234_5678, 32'h1234_5678, 6);  // R4 equal, R7
    run_big(32'h8000_0000, 32'h0000_0001, 7);  // R6 corrected by overflow
    run_big(32'h7FFF_FFFF, 32'h8000_0000, 7);  // R6 corrected by overflow
    run_big(32'h0000_0005, 32'h0000_0006, 7);  // R6 plain
    run_big(32'hF0F0_F0F0, 32'h0FF0_0FF0, 0);  // R1
    run_big(32'hF0F0_F0F0, 32'h0FF0_0FF0, 1);  // R2
    run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3);  // R8
    run_big(32'hFFFF_FFFF, 32'h0000_0000, 4);  // R8
    run_big(32'h8000_0000, 32'h7FFF_FFFF, 5);  // R8

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule